// File: doc/BRIEF.md
# Write-Back Line Cache for a Single-Cycle Data Port

This block is a direct-mapped data cache that sits in front of a memory which works only in whole lines. On the processor side it serves a data port that expects one access per cycle. On the memory side it issues line refills and line write-backs. Loads and stores that hit complete with no delay. A miss raises `stall`. The core's global stall input `stalled` then holds the access until the line has arrived.

Stores follow a write-back, write-allocate policy. A store hit merges the enabled bytes into the cached line and marks the line dirty. A store miss first fetches the line and then merges the bytes into it. Before a dirty line is replaced, it is written back to memory, and that write-back completes before the refill request is issued.

The system ties the core's stall to the OR of this block's `stall` output and any other stall sources, and feeds that same OR back into `stalled`.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid and clean. `stall`, `fill_req_valid`, `evict_req_valid` and `cpu_fault` are low. The first access to any address after reset refills without a write-back, even if the line was dirty before reset.
- R2: A load that hits returns the addressed word on `cpu_rdata` with `cpu_fault` low in the cycle after acceptance. It raises no stall and sends no memory request.
- R3: A request is taken only in a cycle where `cpu_valid` is high and `stalled` is low. A request presented while `stalled` is high leaves `stall` and both memory request valids low.
- R4: A load miss raises `stall` in the cycle after acceptance and issues one refill. When the refill response arrives, `stall` drops and the addressed word of the returned line appears on `cpu_rdata` in the following cycle.
- R5: A store is an access with a nonzero `cpu_wstrb` (all zero means load). Bit b of `cpu_wstrb` replaces byte b of the addressed word. A store hit updates the line, marks it dirty and returns the merged word. Later loads see the merged bytes.
- R6: A store miss refills the line, merges the store bytes into the fetched data, installs the line as dirty and returns the merged word.
- R7: A miss whose victim line is dirty first issues a write-back of the victim's full line and its line address. The refill is issued only after the write-back response. The two request valids are never high together.
- R8: A miss whose victim is clean or invalid issues no write-back.
- R9: A refill response with the fault flag set leaves the line invalid, drives `cpu_fault` high for that access, and causes the next access to the same line to miss again.
- R10: The line layout has the following fixed properties. Word w of a line occupies line bits [w*32 +: 32], so the first-returned memory word sits in the least significant position. The set index is the address field just above the line offset, address bits [5:3] with the default parameters. CPU addresses are word aligned.
- R11: Both memory request addresses are line aligned, with bits [2:0] zero by default. A request holds its valid and address steady until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stalled | input | 1 | Global core stall, fed back from the core |
| stall | output | 1 | High while a miss is being serviced |
| cpu_valid | input | 1 | Access request |
| cpu_addr | input | ADDR_W | Byte address, word aligned |
| cpu_wstrb | input | 2^DATA_SIZE | Byte enables; zero means load |
| cpu_wdata | input | 8<<DATA_SIZE | Store data |
| cpu_rdata | output | 8<<DATA_SIZE | Word returned the cycle after completion |
| cpu_fault | output | 1 | Fault for the completed access |
| fill_req_addr | output | ADDR_W | Line address to refill |
| fill_req_valid | output | 1 | Refill request, held until response |
| fill_rsp_data | input | 8<<LINE_SIZE | Returned line |
| fill_rsp_fault | input | 1 | Refill failed |
| fill_rsp_valid | input | 1 | One-cycle refill response |
| evict_req_addr | output | ADDR_W | Line address of the victim |
| evict_req_data | output | 8<<LINE_SIZE | Victim line contents |
| evict_req_valid | output | 1 | Write-back request, held until response |
| evict_rsp_valid | input | 1 | One-cycle write-back response |

## Verification
The checker relies on three properties of the environment:
- Every accepted CPU address is word aligned.
- `stalled` contains the block's own `stall`, so the core cannot present a new access during a miss.
- Each memory response valid is a single-cycle pulse that arrives only while the matching request is up.

The bench meets all three. It drives `stalled` as the OR of `stall` and a bench-side stall. It uses only aligned addresses. Its memory model answers each request exactly once, after a fixed latency, and drops the pulse on the next cycle.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  // Miss sequencer states; the order of service is write-back then refill.
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_EVICT = 2'd1,
    MS_FILL  = 2'd2
  } miss_state_e;
endpackage

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lookup_miss,
  input  logic        victim_dirty,
  input  logic        evict_ack,
  input  logic        fill_ack,
  output miss_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MS_IDLE;
    end else begin
      unique case (state)
        MS_IDLE:  if (lookup_miss) state <= victim_dirty ? MS_EVICT : MS_FILL;
        MS_EVICT: if (evict_ack) state <= MS_FILL;
        MS_FILL:  if (fill_ack) state <= MS_IDLE;
        default:  state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_tags.sv
module dcache_tags #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 26,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty
);
  logic [SETS-1:0]  valid_vec;
  logic [SETS-1:0]  dirty_vec;
  logic [TAG_W-1:0] tag_vec [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(s)) begin
        v_q <= wr_valid;
        d_q <= wr_dirty;
        t_q <= wr_tag;
      end
    end
    assign valid_vec[s] = v_q;
    assign dirty_vec[s] = d_q;
    assign tag_vec[s]   = t_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
  assign rd_tag   = tag_vec[rd_idx];
endmodule

// File: rtl/dcache_lines.sv
module dcache_lines #(
  parameter int IDX_W  = 3,
  parameter int LINE_W = 64,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] store_q [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_line;
  end

  assign rd_line = store_q[rd_idx];
endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_SIZE = 2,
  parameter int LINE_SIZE = 3,
  parameter int IDX_W     = 3,
  localparam int WORD_W   = 8 << DATA_SIZE,
  localparam int LINE_W   = 8 << LINE_SIZE,
  localparam int STRB_W   = WORD_W / 8,
  localparam int OFF_W    = LINE_SIZE,
  localparam int WSEL_W   = LINE_SIZE - DATA_SIZE,
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W,
  localparam int WADDR_W  = ADDR_W - DATA_SIZE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stalled,
  output logic              stall,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [STRB_W-1:0] cpu_wstrb,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_fault,
  output logic [ADDR_W-1:0] fill_req_addr,
  output logic              fill_req_valid,
  input  logic [LINE_W-1:0] fill_rsp_data,
  input  logic              fill_rsp_fault,
  input  logic              fill_rsp_valid,
  output logic [ADDR_W-1:0] evict_req_addr,
  output logic [LINE_W-1:0] evict_req_data,
  output logic              evict_req_valid,
  input  logic              evict_rsp_valid
);
  // ---- arithmetic helpers ----
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_store(input logic [LINE_W-1:0] line,
                                                    input logic [WSEL_W-1:0] sel,
                                                    input logic [STRB_W-1:0] strb,
                                                    input logic [WORD_W-1:0] data);
    logic [LINE_W-1:0] res;
    res = line;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) res[sel*WORD_W + b*8 +: 8] = data[b*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] tag,
                                                  input logic [IDX_W-1:0] idx);
    return {tag, idx, {OFF_W{1'b0}}};
  endfunction

  // ---- request capture ----
  miss_state_e         state;
  logic [WADDR_W-1:0]  req_word_q;
  logic [STRB_W-1:0]   strb_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [WADDR_W-1:0]  look_word;
  logic [IDX_W-1:0]    look_idx;
  logic [TAG_W-1:0]    look_tag;
  logic [WSEL_W-1:0]   look_sel;

  assign look_word = (state == MS_IDLE) ? cpu_addr[ADDR_W-1:DATA_SIZE] : req_word_q;
  assign look_sel  = look_word[WSEL_W-1:0];
  assign look_idx  = look_word[WSEL_W +: IDX_W];
  assign look_tag  = look_word[WADDR_W-1 -: TAG_W];

  // ---- storage ----
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, rd_dirty;
  logic [LINE_W-1:0] rd_line;
  logic              tag_wr_en, tag_wr_valid, tag_wr_dirty;
  logic              line_wr_en;
  logic [LINE_W-1:0] line_wr_data;

  dcache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(look_idx), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .wr_en(tag_wr_en),
    .wr_idx(look_idx), .wr_tag(look_tag), .wr_valid(tag_wr_valid),
    .wr_dirty(tag_wr_dirty)
  );

  dcache_lines #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .rd_idx(look_idx), .rd_line(rd_line),
    .wr_en(line_wr_en), .wr_idx(look_idx), .wr_line(line_wr_data)
  );

  // ---- named events ----
  logic accept, tag_hit, hit_evt, miss_evt, store_now, store_q;
  logic evict_ack, fill_ack, fill_good;
  logic [LINE_W-1:0] hit_line, fill_line;

  assign accept    = cpu_valid && !stalled && (state == MS_IDLE);
  assign tag_hit   = rd_valid && (rd_tag == look_tag);
  assign hit_evt   = accept && tag_hit;
  assign miss_evt  = accept && !tag_hit;
  assign store_now = |cpu_wstrb;
  assign store_q   = |strb_q;
  assign evict_ack = (state == MS_EVICT) && evict_rsp_valid;
  assign fill_ack  = (state == MS_FILL) && fill_rsp_valid;
  assign fill_good = fill_ack && !fill_rsp_fault;

  assign hit_line  = merge_store(rd_line, look_sel, cpu_wstrb, cpu_wdata);
  assign fill_line = merge_store(fill_rsp_data, look_sel, strb_q, wdata_q);

  assign tag_wr_en    = (hit_evt && store_now) || fill_ack;
  assign tag_wr_valid = hit_evt || fill_good;
  assign tag_wr_dirty = hit_evt || (fill_good && store_q);
  assign line_wr_en   = (hit_evt && store_now) || fill_good;
  assign line_wr_data = hit_evt ? hit_line : fill_line;

  dcache_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lookup_miss(miss_evt),
    .victim_dirty(rd_valid && rd_dirty), .evict_ack(evict_ack),
    .fill_ack(fill_ack), .state(state)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      req_word_q <= cpu_addr[ADDR_W-1:DATA_SIZE];
      strb_q     <= cpu_wstrb;
      wdata_q    <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      cpu_fault <= 1'b0;
    end else if (hit_evt) begin
      cpu_rdata <= pick_word(hit_line, look_sel);
      cpu_fault <= 1'b0;
    end else if (fill_ack) begin
      cpu_rdata <= pick_word(fill_line, look_sel);
      cpu_fault <= fill_rsp_fault;
    end
  end

  // ---- outputs ----
  assign stall           = (state != MS_IDLE);
  assign fill_req_valid  = (state == MS_FILL);
  assign fill_req_addr   = line_base(look_tag, look_idx);
  assign evict_req_valid = (state == MS_EVICT);
  assign evict_req_addr  = line_base(rd_tag, look_idx);
  assign evict_req_data  = rd_line;
endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_SIZE = 2,
  parameter int OFF_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              stalled,
  input logic              cpu_valid,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              stall,
  input logic              fill_req_valid,
  input logic [ADDR_W-1:0] fill_req_addr,
  input logic              fill_rsp_valid,
  input logic              evict_req_valid,
  input logic [ADDR_W-1:0] evict_req_addr,
  input logic              evict_rsp_valid,
  input logic              hit_evt
);
  logic rst_prev;

  always @(posedge clk) begin
    if (rst_prev && !rst)
      AST_RESET_QUIET: assert (!stall && !fill_req_valid && !evict_req_valid); // R1
    rst_prev <= rst;
  end

  AST_WORD_ALIGNED_IN: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !stalled) |-> cpu_addr[DATA_SIZE-1:0] == '0); // R10
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> !stall); // R2
  AST_REQ_MEANS_STALL: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid || evict_req_valid) |-> stall); // R4
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (rst)
    !(fill_req_valid && evict_req_valid)); // R7
  AST_FILL_AFTER_EVICT: assert property (@(posedge clk) disable iff (rst)
    (evict_req_valid && evict_rsp_valid) |=> fill_req_valid); // R7
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> fill_req_addr[OFF_W-1:0] == '0); // R11
  AST_EVICT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    evict_req_valid |-> evict_req_addr[OFF_W-1:0] == '0); // R11
  AST_FILL_HELD: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr))); // R11
  AST_EVICT_HELD: assert property (@(posedge clk) disable iff (rst)
    (evict_req_valid && !evict_rsp_valid) |=> (evict_req_valid && $stable(evict_req_addr))); // R11
endmodule

bind dcache_wb dcache_wb_chk #(
  .ADDR_W(ADDR_W), .DATA_SIZE(DATA_SIZE), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .stalled(stalled), .cpu_valid(cpu_valid),
  .cpu_addr(cpu_addr), .stall(stall), .fill_req_valid(fill_req_valid),
  .fill_req_addr(fill_req_addr), .fill_rsp_valid(fill_rsp_valid),
  .evict_req_valid(evict_req_valid), .evict_req_addr(evict_req_addr),
  .evict_rsp_valid(evict_rsp_valid), .hit_evt(hit_evt)
);

// File: tb/dcache_wb_tb.sv
module dcache_wb_tb;
  logic clk = 1'b0;
  always #2.5ns clk = ~clk;

  logic        rst, ext_stall, stalled, stall;
  logic        cpu_valid, cpu_fault;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_wstrb;
  logic [31:0] fill_req_addr, evict_req_addr;
  logic        fill_req_valid, evict_req_valid;
  logic [63:0] fill_rsp_data, evict_req_data;
  logic        fill_rsp_fault, fill_rsp_valid, evict_rsp_valid;

  assign stalled = stall | ext_stall;

  dcache_wb u_dut (
    .clk(clk), .rst(rst), .stalled(stalled), .stall(stall),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_wstrb(cpu_wstrb),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_fault(cpu_fault),
    .fill_req_addr(fill_req_addr), .fill_req_valid(fill_req_valid),
    .fill_rsp_data(fill_rsp_data), .fill_rsp_fault(fill_rsp_fault),
    .fill_rsp_valid(fill_rsp_valid), .evict_req_addr(evict_req_addr),
    .evict_req_data(evict_req_data), .evict_req_valid(evict_req_valid),
    .evict_rsp_valid(evict_rsp_valid)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---- backing memory model: word at byte address a holds a ^ 5A5A0000 ----
  logic [63:0] mem [128];
  logic [31:0] fault_line = 32'hFFFF_FFFF;
  int fill_cnt = 0, evict_cnt = 0, fwait = 0, ewait = 0;
  logic [31:0] last_fill_addr, last_evict_addr;
  logic [63:0] last_evict_data;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = {pat(i*8 + 4), pat(i*8)};
    fill_rsp_valid = 0; evict_rsp_valid = 0; fill_rsp_fault = 0; fill_rsp_data = '0;
  end

  always @(negedge clk) begin
    if (fill_rsp_valid) fill_rsp_valid = 0;
    else if (fill_req_valid) begin
      if (fwait == 2) begin
        fwait = 0;
        fill_cnt++;
        last_fill_addr = fill_req_addr;
        fill_rsp_data  = mem[fill_req_addr[9:3]];
        fill_rsp_fault = (fill_req_addr == fault_line);
        fill_rsp_valid = 1;
      end else fwait++;
    end
    if (evict_rsp_valid) evict_rsp_valid = 0;
    else if (evict_req_valid) begin
      if (ewait == 1) begin
        ewait = 0;
        evict_cnt++;
        last_evict_addr = evict_req_addr;
        last_evict_data = evict_req_data;
        mem[evict_req_addr[9:3]] = evict_req_data;
        evict_rsp_valid = 1;
      end else ewait++;
    end
  end

  // ---- access task ----
  logic [31:0] rd;
  logic        flt;
  int          stl;

  task automatic access(input logic [31:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    cpu_valid = 1; cpu_addr = a; cpu_wstrb = s; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 0; cpu_wstrb = 0;
    stl = 0;
    while (stall) begin
      stl++;
      @(negedge clk);
    end
    rd = cpu_rdata; flt = cpu_fault;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        fault;
    logic [1:0]  fills;
    logic [1:0]  evicts;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{32'h040, 4'h0, 32'h0,         32'h5A5A0040, 1'b0, 2'd1, 2'd0}, // R4 cold miss
    '{32'h044, 4'h0, 32'h0,         32'h5A5A0044, 1'b0, 2'd0, 2'd0}, // R2 hit
    '{32'h044, 4'h3, 32'h1234BEEF,  32'h5A5ABEEF, 1'b0, 2'd0, 2'd0}, // R5 store hit
    '{32'h044, 4'h0, 32'h0,         32'h5A5ABEEF, 1'b0, 2'd0, 2'd0}, // R5 readback
    '{32'h080, 4'h0, 32'h0,         32'h5A5A0080, 1'b0, 2'd1, 2'd1}, // R7 dirty victim
    '{32'h044, 4'h0, 32'h0,         32'h5A5ABEEF, 1'b0, 2'd1, 2'd0}, // R8 clean victim, R7 data
    '{32'h0C8, 4'h8, 32'hAB000000,  32'hAB5A00C8, 1'b0, 2'd1, 2'd0}, // R6 store miss
    '{32'h0C8, 4'h0, 32'h0,         32'hAB5A00C8, 1'b0, 2'd0, 2'd0}, // R6 allocated
    '{32'h108, 4'h0, 32'h0,         32'h5A5A0108, 1'b0, 2'd1, 2'd1}, // R7 dirty victim
    '{32'h0CC, 4'h0, 32'h0,         32'h5A5A00CC, 1'b0, 2'd1, 2'd0}, // R8
    '{32'h0CC, 4'hF, 32'hFFFF0000,  32'hFFFF0000, 1'b0, 2'd0, 2'd0}, // R5 full word
    '{32'h0C8, 4'h0, 32'h0,         32'hAB5A00C8, 1'b0, 2'd0, 2'd0}  // R2 hit
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0, e0;
    rst = 1; ext_stall = 0; cpu_valid = 0; cpu_addr = 0; cpu_wstrb = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!stall && !fill_req_valid && !evict_req_valid && !cpu_fault,
        "R1 reset quiet", {stall, fill_req_valid, evict_req_valid, cpu_fault}, 0);

    for (int i = 0; i < 12; i++) begin
      f0 = fill_cnt; e0 = evict_cnt;
      access(VEC[i].addr, VEC[i].strb, VEC[i].wdata);
      chk(rd == VEC[i].exp, $sformatf("R2 R4 R5 R6 rdata vec %0d", i), rd, VEC[i].exp);
      chk(flt == VEC[i].fault, $sformatf("R2 fault vec %0d", i), flt, VEC[i].fault);
      chk(fill_cnt - f0 == VEC[i].fills, $sformatf("R4 R6 fills vec %0d", i), fill_cnt - f0, VEC[i].fills);
      chk(evict_cnt - e0 == VEC[i].evicts, $sformatf("R7 R8 evicts vec %0d", i), evict_cnt - e0, VEC[i].evicts);
      if (VEC[i].fills == 0) chk(stl == 0, $sformatf("R2 no stall vec %0d", i), stl, 0);
    end

    chk(last_evict_addr == 32'h0C8, "R7 victim address", last_evict_addr, 32'h0C8);
    chk(last_evict_data == 64'h5A5A00CC_AB5A00C8, "R10 victim line layout", last_evict_data, 64'h5A5A00CC_AB5A00C8);
    chk(last_fill_addr == 32'h0C8, "R11 aligned refill address", last_fill_addr, 32'h0C8);

    // R3: request under external stall is ignored
    @(negedge clk);
    ext_stall = 1; cpu_valid = 1; cpu_addr = 32'h200; cpu_wstrb = 0;
    repeat (4) @(negedge clk);
    chk(!stall && !fill_req_valid && !evict_req_valid, "R3 ignored while stalled",
        {stall, fill_req_valid, evict_req_valid}, 0);
    cpu_valid = 0; ext_stall = 0;
    f0 = fill_cnt;
    access(32'h200, 4'h0, 32'h0);
    chk(rd == 32'h5A5A0200 && fill_cnt - f0 == 1, "R3 later accepted", rd, 32'h5A5A0200);

    // R9: refill fault
    fault_line = 32'h300;
    f0 = fill_cnt;
    access(32'h300, 4'h0, 32'h0);
    chk(flt == 1, "R9 fault raised", flt, 1);
    access(32'h304, 4'h0, 32'h0);
    chk(flt == 1 && fill_cnt - f0 == 2, "R9 line stays invalid", fill_cnt - f0, 2);
    fault_line = 32'hFFFF_FFFF;
    f0 = fill_cnt;
    access(32'h304, 4'h0, 32'h0);
    chk(flt == 0 && rd == 32'h5A5A0304 && fill_cnt - f0 == 1, "R9 recovery", rd, 32'h5A5A0304);

    // R1: reset drops dirty line at set 1 without write-back
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!stall && !cpu_fault, "R1 quiet after mid-run reset", {stall, cpu_fault}, 0);
    f0 = fill_cnt; e0 = evict_cnt;
    access(32'h108, 4'h0, 32'h0);
    chk(fill_cnt - f0 == 1 && evict_cnt == e0, "R1 lines invalid and clean", evict_cnt - e0, 0);
    chk(rd == 32'h5A5A0108, "R1 refill data", rd, 32'h5A5A0108);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule